// File: doc/BRIEF.md
# Descriptor Table Fetch Unit

This unit takes a 16-bit segment selector and fetches the matching descriptor from one of two in-memory descriptor tables: the global table or the local table. The request also carries the base and byte limit of both tables, a valid bit for the local table, a width mode (one 8-byte entry or one 16-byte entry) and a reporting mode. Before any memory access the unit decides which table the selector names. It refuses the request if that table is the local one and its valid bit is clear. It also refuses the request if the last byte of the entry would lie beyond the table limit. A request that passes these checks drives one or two 64-bit reads on a valid/ready read port and returns the fetched 32-bit words.

Two reporting modes exist. In faulting mode a refused request returns an exception flag, an exception vector and an error code. In quiet mode it only returns a cleared status bit. In 16-byte mode the second 64-bit word carries a reserved type field that must be zero. A nonzero value there is refused, and in faulting mode it always reports the general-protection vector, whatever vector the request asked for. The unit accepts one request at a time and stays busy until it has sent the response.

Top module: `desc_fetch_unit`

## Requirements
- R1: The selector index is bits 15:3 and bit 2 picks the table (0 global, 1 local). The first read address is that table's base plus index*8.
- R2: A request that names the local table while `ldt_valid` is 0 is refused.
- R3: In 8-byte mode the request is refused when index*8+7 is greater than the chosen table's limit. It is accepted when the two are equal.
- R4: In 16-byte mode the request is refused when index*8+15 is greater than the chosen table's limit.
- R5: A request refused by the table or limit check issues no memory read.
- R6: An accepted 8-byte request makes exactly one read. `rsp_word1` is bits 31:0 and `rsp_word2` is bits 63:32 of the returned qword.
- R7: An accepted 16-byte request makes a second read at the first address plus 8. `rsp_word3` is bits 31:0 of that second qword.
- R8: In 16-byte mode the request is refused when any of bits 44:40 of the second qword is 1. In faulting mode this reports vector GP_VEC (default 13), not the requested one.
- R9: In faulting mode (`req_fault`=1) a refusal returns `rsp_ok`=0, `rsp_exc`=1, `rsp_exc_num` equal to the requested vector (except under R8), and `rsp_err_code` equal to the selector with bits 1:0 cleared.
- R10: In quiet mode a refusal returns `rsp_ok`=0, `rsp_exc`=0, `rsp_exc_num`=0 and `rsp_err_code`=0. A success always has `rsp_ok`=1 and `rsp_exc`=0.
- R11: Only one request is in flight. `req_ready` is 0 and `busy` is 1 from the accepting edge until the single-cycle `rsp_valid` pulse ends, and each accepted request gets exactly one response.
- R12: Out of synchronous active-high reset the unit has `req_ready`=1, `busy`=0, `rsp_valid`=0 and `rd_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request accepted this cycle if valid |
| req_sel | input | 16 | Selector: index 15:3, table bit 2, privilege 1:0 |
| req_wide | input | 1 | 1 = 16-byte entry, 0 = 8-byte entry |
| req_fault | input | 1 | 1 = faulting mode, 0 = quiet mode |
| req_exc | input | EXC_W | Vector reported for check failures in faulting mode |
| gdt_base | input | ADDR_W | Global table base address |
| gdt_limit | input | LIM_W | Global table byte limit |
| ldt_base | input | ADDR_W | Local table base address |
| ldt_limit | input | LIM_W | Local table byte limit |
| ldt_valid | input | 1 | Local table register holds a usable value |
| busy | output | 1 | Request in flight |
| rd_valid | output | 1 | Read request present |
| rd_ready | input | 1 | Memory accepts read request |
| rd_addr | output | ADDR_W | Read byte address |
| rd_rvalid | input | 1 | Read data returned |
| rd_rdata | input | 64 | Read data qword |
| rsp_valid | output | 1 | Response pulse |
| rsp_ok | output | 1 | Fetch succeeded |
| rsp_exc | output | 1 | Exception raised |
| rsp_exc_num | output | EXC_W | Exception vector |
| rsp_err_code | output | 16 | Error code |
| rsp_word1 | output | 32 | Low half of first qword |
| rsp_word2 | output | 32 | High half of first qword |
| rsp_word3 | output | 32 | Low half of second qword |

## Verification
The bench tests entries that end exactly on the table limit and entries one slot past it, in both widths and in both tables. An off-by-one or wrapping comparison would accept the last illegal slot or refuse the last legal one. It sends a local-table request with the valid bit cleared, which a unit ignoring that bit would fetch. It also counts memory reads per request, so a unit that issues a read before failing its bounds check shows up. A second qword with a reserved bit set is fetched in both modes. A unit that passed through the requested vector, or that set the exception flag in quiet mode, would report the wrong outcome. Error codes come from selectors with nonzero privilege bits, which catches a missing mask.

// File: rtl/desc_fetch_pkg.sv
package desc_fetch_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RESP  = 2'd3
  } df_state_t;

  localparam int QW_W    = 64;
  localparam int WORD_W  = 32;
  localparam int SEL_W   = 16;
  localparam int RSV_LO  = 40;
  localparam int RSV_HI  = 44;
  localparam logic [SEL_W-1:0] ERR_MASK = 16'hFFFC;
endpackage

// File: rtl/df_check.sv
module df_check
  import desc_fetch_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LIM_W  = 32
) (
  input  logic [SEL_W-1:0]  sel,
  input  logic              wide,
  input  logic [ADDR_W-1:0] gdt_base,
  input  logic [LIM_W-1:0]  gdt_limit,
  input  logic [ADDR_W-1:0] ldt_base,
  input  logic [LIM_W-1:0]  ldt_limit,
  input  logic              ldt_valid,
  output logic              pass,
  output logic [ADDR_W-1:0] addr
);
  // sum is wide enough that index*8+15 can never wrap
  localparam int SUM_W = ((LIM_W > SEL_W) ? LIM_W : SEL_W) + 2;

  logic [SUM_W-1:0] offs;
  logic [SUM_W-1:0] last_byte;
  logic [SUM_W-1:0] limit_ext;
  logic             use_local;

  always_comb begin
    use_local = sel[2];
    offs      = SUM_W'({sel[SEL_W-1:3], 3'b000});
    last_byte = offs + (wide ? SUM_W'(15) : SUM_W'(7));
    limit_ext = use_local ? SUM_W'(ldt_limit) : SUM_W'(gdt_limit);
    pass      = !(use_local && !ldt_valid) && (last_byte <= limit_ext);
    addr      = (use_local ? ldt_base : gdt_base) + ADDR_W'({sel[SEL_W-1:3], 3'b000});
  end
endmodule

// File: rtl/df_ctrl.sv
module df_ctrl
  import desc_fetch_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int EXC_W  = 8,
  parameter int GP_VEC = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [SEL_W-1:0]  req_sel,
  input  logic              req_wide,
  input  logic              req_fault,
  input  logic [EXC_W-1:0]  req_exc,
  input  logic              chk_pass,
  input  logic [ADDR_W-1:0] chk_addr,
  output logic              req_ready,
  output logic              busy,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_rvalid,
  input  logic [QW_W-1:0]   rd_rdata,
  output logic              rsp_valid,
  output logic              rsp_ok,
  output logic              rsp_exc,
  output logic [EXC_W-1:0]  rsp_exc_num,
  output logic [SEL_W-1:0]  rsp_err_code,
  output logic [WORD_W-1:0] rsp_word1,
  output logic [WORD_W-1:0] rsp_word2,
  output logic [WORD_W-1:0] rsp_word3
);
  localparam logic [EXC_W-1:0]  GP_CODE = EXC_W'(GP_VEC);
  localparam logic [ADDR_W-1:0] QW_STEP = ADDR_W'(8);

  df_state_t        state;
  logic             wide_q, fault_q, second_q;
  logic [SEL_W-1:0] sel_q;
  logic [ADDR_W-1:0] addr_q;
  logic             rsv_bad;

  assign req_ready = (state == ST_IDLE);
  assign busy      = (state != ST_IDLE);
  assign rd_valid  = (state == ST_ISSUE);
  assign rd_addr   = addr_q;
  assign rsp_valid = (state == ST_RESP);
  assign rsv_bad   = |rd_rdata[RSV_HI:RSV_LO];

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      wide_q       <= 1'b0;
      fault_q      <= 1'b0;
      second_q     <= 1'b0;
      sel_q        <= '0;
      addr_q       <= '0;
      rsp_ok       <= 1'b0;
      rsp_exc      <= 1'b0;
      rsp_exc_num  <= '0;
      rsp_err_code <= '0;
      rsp_word1    <= '0;
      rsp_word2    <= '0;
      rsp_word3    <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            sel_q    <= req_sel;
            wide_q   <= req_wide;
            fault_q  <= req_fault;
            second_q <= 1'b0;
            addr_q   <= chk_addr;
            if (chk_pass) begin
              state <= ST_ISSUE;
            end else begin
              rsp_ok       <= 1'b0;
              rsp_exc      <= req_fault;
              rsp_exc_num  <= req_fault ? req_exc : '0;
              rsp_err_code <= req_fault ? (req_sel & ERR_MASK) : '0;
              state        <= ST_RESP;
            end
          end
        end
        ST_ISSUE: begin
          if (rd_ready) state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (rd_rvalid) begin
            if (!second_q) begin
              rsp_word1 <= rd_rdata[WORD_W-1:0];
              rsp_word2 <= rd_rdata[QW_W-1:WORD_W];
              if (wide_q) begin
                addr_q   <= addr_q + QW_STEP;
                second_q <= 1'b1;
                state    <= ST_ISSUE;
              end else begin
                rsp_ok       <= 1'b1;
                rsp_exc      <= 1'b0;
                rsp_exc_num  <= '0;
                rsp_err_code <= '0;
                state        <= ST_RESP;
              end
            end else begin
              rsp_word3 <= rd_rdata[WORD_W-1:0];
              if (rsv_bad) begin
                rsp_ok       <= 1'b0;
                rsp_exc      <= fault_q;
                rsp_exc_num  <= fault_q ? GP_CODE : '0;
                rsp_err_code <= fault_q ? (sel_q & ERR_MASK) : '0;
              end else begin
                rsp_ok       <= 1'b1;
                rsp_exc      <= 1'b0;
                rsp_exc_num  <= '0;
                rsp_err_code <= '0;
              end
              state <= ST_RESP;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/desc_fetch_unit.sv
module desc_fetch_unit
  import desc_fetch_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LIM_W  = 32,
  parameter int EXC_W  = 8,
  parameter int GP_VEC = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [15:0]       req_sel,
  input  logic              req_wide,
  input  logic              req_fault,
  input  logic [EXC_W-1:0]  req_exc,
  input  logic [ADDR_W-1:0] gdt_base,
  input  logic [LIM_W-1:0]  gdt_limit,
  input  logic [ADDR_W-1:0] ldt_base,
  input  logic [LIM_W-1:0]  ldt_limit,
  input  logic              ldt_valid,
  output logic              busy,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_rvalid,
  input  logic [63:0]       rd_rdata,
  output logic              rsp_valid,
  output logic              rsp_ok,
  output logic              rsp_exc,
  output logic [EXC_W-1:0]  rsp_exc_num,
  output logic [15:0]       rsp_err_code,
  output logic [31:0]       rsp_word1,
  output logic [31:0]       rsp_word2,
  output logic [31:0]       rsp_word3
);
  logic              chk_pass;
  logic [ADDR_W-1:0] chk_addr;

  df_check #(.ADDR_W(ADDR_W), .LIM_W(LIM_W)) u_check (
    .sel       (req_sel),
    .wide      (req_wide),
    .gdt_base  (gdt_base),
    .gdt_limit (gdt_limit),
    .ldt_base  (ldt_base),
    .ldt_limit (ldt_limit),
    .ldt_valid (ldt_valid),
    .pass      (chk_pass),
    .addr      (chk_addr)
  );

  df_ctrl #(.ADDR_W(ADDR_W), .EXC_W(EXC_W), .GP_VEC(GP_VEC)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_sel      (req_sel),
    .req_wide     (req_wide),
    .req_fault    (req_fault),
    .req_exc      (req_exc),
    .chk_pass     (chk_pass),
    .chk_addr     (chk_addr),
    .req_ready    (req_ready),
    .busy         (busy),
    .rd_valid     (rd_valid),
    .rd_ready     (rd_ready),
    .rd_addr      (rd_addr),
    .rd_rvalid    (rd_rvalid),
    .rd_rdata     (rd_rdata),
    .rsp_valid    (rsp_valid),
    .rsp_ok       (rsp_ok),
    .rsp_exc      (rsp_exc),
    .rsp_exc_num  (rsp_exc_num),
    .rsp_err_code (rsp_err_code),
    .rsp_word1    (rsp_word1),
    .rsp_word2    (rsp_word2),
    .rsp_word3    (rsp_word3)
  );
endmodule

// File: rtl/desc_fetch_chk.sv
module desc_fetch_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_wide,
  input logic              busy,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rsp_valid,
  input logic              rsp_ok,
  input logic              rsp_exc,
  input logic [15:0]       rsp_err_code
);
  logic [1:0] reads_cnt;
  logic       wide_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      reads_cnt <= '0;
      wide_seen <= 1'b0;
    end else if (req_valid && req_ready) begin
      reads_cnt <= '0;
      wide_seen <= req_wide;
    end else if (rd_valid && rd_ready) begin
      reads_cnt <= reads_cnt + 2'd1;
    end
  end

  assert_accept_busy_R11: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (!req_ready && busy));

  assert_rsp_single_R11: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> (req_ready && !rsp_valid));

  assert_read_in_flight_R5: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> busy);

  assert_addr_hold_R1: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));

  assert_read_count_R7: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_ok) |-> (reads_cnt == (wide_seen ? 2'd2 : 2'd1)));

  assert_ok_no_exc_R10: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_ok) |-> !rsp_exc);

  assert_err_masked_R9: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_exc) |-> (rsp_err_code[1:0] == 2'b00));
endmodule

bind desc_fetch_unit desc_fetch_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_wide     (req_wide),
  .busy         (busy),
  .rd_valid     (rd_valid),
  .rd_ready     (rd_ready),
  .rd_addr      (rd_addr),
  .rsp_valid    (rsp_valid),
  .rsp_ok       (rsp_ok),
  .rsp_exc      (rsp_exc),
  .rsp_err_code (rsp_err_code)
);

// File: tb/sim_desc_fetch_unit.sv
module sim_desc_fetch_unit;
  localparam logic [31:0] GBASE = 32'h0001_0000;
  localparam logic [31:0] GLIM  = 32'h0000_00FF;
  localparam logic [31:0] LBASE = 32'h0002_0400;
  localparam logic [31:0] LLIM  = 32'h0000_003F;
  localparam logic [31:0] BAD   = GBASE + 32'd48;  // second qword of global index 5

  typedef struct {
    logic        ok;
    logic        exc;
    logic [7:0]  num;
    logic [15:0] err;
    logic [31:0] w1, w2, w3;
    int          nrd;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_wide = 1'b0, req_fault = 1'b0, ldt_valid = 1'b1;
  logic [15:0] req_sel = '0;
  logic [7:0]  req_exc = '0;
  logic req_ready, busy, rd_valid, rd_rvalid, rsp_valid, rsp_ok, rsp_exc;
  logic rd_ready;
  logic [31:0] rd_addr, rsp_word1, rsp_word2, rsp_word3;
  logic [63:0] rd_rdata;
  logic [7:0]  rsp_exc_num;
  logic [15:0] rsp_err_code;

  int n_checks = 0, n_fail = 0, rd_total = 0, rd_seen = 0;
  exp_t  expq[$];
  string tagq[$];

  always #2 clk = ~clk;

  desc_fetch_unit u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_sel(req_sel), .req_wide(req_wide), .req_fault(req_fault), .req_exc(req_exc),
    .gdt_base(GBASE), .gdt_limit(GLIM), .ldt_base(LBASE), .ldt_limit(LLIM),
    .ldt_valid(ldt_valid), .busy(busy), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_addr(rd_addr), .rd_rvalid(rd_rvalid), .rd_rdata(rd_rdata),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_exc(rsp_exc),
    .rsp_exc_num(rsp_exc_num), .rsp_err_code(rsp_err_code),
    .rsp_word1(rsp_word1), .rsp_word2(rsp_word2), .rsp_word3(rsp_word3)
  );

  function automatic logic [63:0] qw(input logic [31:0] a);
    logic [31:0] hi;
    hi = (a ^ 32'h1357_9BDF) & ~32'h0000_1F00;
    if (a == BAD) hi = hi | 32'h0000_0400;  // bit 42 of the qword
    return {hi, a + 32'h0F0F_0000};
  endfunction

  // memory model: ready toggles, data one cycle after the handshake
  logic rdy_t = 1'b0;
  assign rd_ready = rdy_t;
  always @(posedge clk) begin
    rdy_t     <= ~rdy_t;
    rd_rvalid <= 1'b0;
    if (rd_valid && rd_ready) begin
      rd_rvalid <= 1'b1;
      rd_rdata  <= qw(rd_addr);
      rd_total  <= rd_total + 1;
    end
  end

  task automatic check(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  task automatic send(input logic [15:0] sel, input logic wide, input logic flt,
                      input logic [7:0] ex, input string tag);
    exp_t e;
    logic [31:0] last, lim, a;
    logic [63:0] q1, q2;
    logic fail;
    logic [7:0] vec;
    last = {16'h0, sel[15:3], 3'b000} + (wide ? 32'd15 : 32'd7);
    lim  = sel[2] ? LLIM : GLIM;
    a    = (sel[2] ? LBASE : GBASE) + {16'h0, sel[15:3], 3'b000};
    fail = (sel[2] && !ldt_valid) || (last > lim);
    vec  = ex;
    e.nrd = 0; e.w1 = '0; e.w2 = '0; e.w3 = '0;
    if (!fail) begin
      q1 = qw(a); e.w1 = q1[31:0]; e.w2 = q1[63:32]; e.nrd = 1;
      if (wide) begin
        q2 = qw(a + 32'd8); e.w3 = q2[31:0]; e.nrd = 2;
        if (q2[44:40] != 5'd0) begin fail = 1'b1; vec = 8'd13; end
      end
    end
    e.ok  = !fail;
    e.exc = fail && flt;
    e.num = (fail && flt) ? vec : 8'd0;
    e.err = (fail && flt) ? (sel & 16'hFFFC) : 16'd0;
    expq.push_back(e);
    tagq.push_back(tag);
    do @(negedge clk); while (!req_ready);
    req_sel = sel; req_wide = wide; req_fault = flt; req_exc = ex;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R11", "busy after accept", {63'd0, busy}, 64'd1);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      exp_t  e;
      string t;
      if (expq.size() == 0) begin
        check("R11", "unexpected response", 64'd1, 64'd0);
      end else begin
        e = expq.pop_front();
        t = tagq.pop_front();
        check(t, "ok", {63'd0, rsp_ok}, {63'd0, e.ok});
        check(t, "exc", {63'd0, rsp_exc}, {63'd0, e.exc});
        check(t, "exc_num", {56'd0, rsp_exc_num}, {56'd0, e.num});
        check(t, "err_code", {48'd0, rsp_err_code}, {48'd0, e.err});
        check(t, "reads", 64'(rd_total - rd_seen), 64'(e.nrd));
        if (e.ok) begin
          check(t, "word1", {32'd0, rsp_word1}, {32'd0, e.w1});
          check(t, "word2", {32'd0, rsp_word2}, {32'd0, e.w2});
          if (e.nrd == 2) check(t, "word3", {32'd0, rsp_word3}, {32'd0, e.w3});
        end
      end
      rd_seen = rd_total;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R12", "ready in reset", {63'd0, req_ready}, 64'd1);
    check("R12", "busy in reset", {63'd0, busy}, 64'd0);
    check("R12", "rsp_valid in reset", {63'd0, rsp_valid}, 64'd0);
    check("R12", "rd_valid in reset", {63'd0, rd_valid}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    // global table, 8-byte
    send({13'd3, 1'b0, 2'd2}, 1'b0, 1'b1, 8'd10, "R1_R6");
    send({13'd31, 1'b0, 2'd0}, 1'b0, 1'b1, 8'd10, "R3_global_edge");
    send({13'd32, 1'b0, 2'd3}, 1'b0, 1'b0, 8'd10, "R3_R5_R10_global_over");
    // local table
    send({13'd7, 1'b1, 2'd1}, 1'b0, 1'b1, 8'd10, "R3_R1_local_edge");
    send({13'd8, 1'b1, 2'd3}, 1'b0, 1'b1, 8'd10, "R3_R5_R9_local_over");
    send({13'd7, 1'b1, 2'd2}, 1'b1, 1'b0, 8'd10, "R4_R10_wide_over");
    send({13'd6, 1'b1, 2'd0}, 1'b1, 1'b1, 8'd10, "R4_R7_wide_edge");
    send({13'd30, 1'b0, 2'd1}, 1'b1, 1'b1, 8'd10, "R7_global_wide");
    send({13'd31, 1'b0, 2'd1}, 1'b1, 1'b1, 8'd9, "R4_R9_global_wide_over");
    // reserved type field in second qword
    send({13'd5, 1'b0, 2'd3}, 1'b1, 1'b1, 8'd11, "R8_fault");
    send({13'd5, 1'b0, 2'd1}, 1'b1, 1'b0, 8'd11, "R8_R10_quiet");
    send({13'd6, 1'b0, 2'd0}, 1'b0, 1'b1, 8'd11, "R6_R8_narrow_ignores");
    // local table marked invalid
    ldt_valid = 1'b0;
    send({13'd1, 1'b1, 2'd3}, 1'b0, 1'b1, 8'd12, "R2_R5_fault");
    send({13'd0, 1'b1, 2'd0}, 1'b0, 1'b0, 8'd12, "R2_R10_quiet");
    send({13'd2, 1'b0, 2'd0}, 1'b0, 1'b1, 8'd12, "R2_global_unaffected");
    ldt_valid = 1'b1;
    while (expq.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL R11 watchdog: actual no response expected response");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule